// File: doc/BRIEF.md
# Interval Timer Register Port

This block is the byte-wide programming and readback front end of a three-channel interval timer. One address takes control words. Three more addresses each carry the data bytes of one channel. The block decodes each control word in one of two ways. It either programs a channel's configuration, or it issues a snapshot command. A programming word sets the byte access type, the counting mode and the binary/BCD select. A snapshot command freezes the count or a status byte of one or more channels.

Data writes are put together into 16-bit reload values. Each completed value goes to the counting engine with a one-cycle load strobe. The counting engines are outside this block. They provide the live count, the output pin level and a loaded flag for each channel. A read returns a held snapshot while one is pending, and the live count otherwise. The access type of the channel decides which byte is returned.

Top module: `timer_port`

## Requirements
- R1: After reset every reload value is 0 and no load strobe is active. Every channel is set to two-byte access (low byte, then high byte), mode 0 and binary counting. Data reads return the live count, low byte first.
- R2: A write to address 3 with bits 7:6 equal to 00, 01 or 10 and bits 5:4 not 00 programs channel 0, 1 or 2. Bits 5:4 set the access type (01 low only, 10 high only, 11 low then high). Bits 3:1 set the mode and bit 0 sets BCD (1) or binary (0). Only such a write changes a channel's configuration.
- R3: In low-only access, a data write loads {8'h00, byte}. In high-only access it loads {byte, 8'h00}. The channel's load strobe is high for the one cycle that follows the write.
- R4: In two-byte access, the first data byte is the low byte and the second is the high byte. The load strobe pulses only after the second byte, and the first byte leaves the reload value unchanged.
- R5: Reads follow the access type: low-only returns the low byte, high-only returns the high byte, and two-byte alternates low then high. The read byte order and the write byte order advance independently. Programming a channel returns both orders to the low byte.
- R6: A control word with bits 7:6 naming a channel and bits 5:4 = 00 freezes that channel's count. Reads return the frozen value until its last byte has been read, and then they follow the live count again.
- R7: A count snapshot command to a channel that already holds an unread snapshot is ignored.
- R8: Control word bits 7:4 = 1101 freezes the counts of the channels selected by bit 3 (channel 2), bit 2 (channel 1) and bit 1 (channel 0).
- R9: Bits 7:4 = 1110 captures a status byte for the channels selected by bit 3 (channel 2), bit 2 (channel 1) and bit 1 (channel 0). The status byte holds the output pin in bit 7 and the loaded flag in bit 6. Bits 5:4 give the access type as 01 for high only, 10 for low only and 11 for two-byte. Bits 3:1 give the mode and bit 0 the BCD flag. A second status command is ignored until the status byte has been read.
- R10: When both a status byte and a count snapshot are pending on a channel, the status byte is read first and the count bytes follow it.
- R11: Control words with bits 7:4 = 1100 or 1111 change no configuration and capture no snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | 0..2 select a channel's data byte, 3 selects the control word |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Byte written |
| rdEn | input | 1 | Byte read strobe; advances the read sequence |
| rdData | output | 8 | Byte returned at busAddr (0 at the control address) |
| liveCount | input | 48 | Live count of each channel, channel 0 in bits 15:0 |
| outPin | input | 3 | Output pin level of each channel |
| loadedFlag | input | 3 | Count-loaded flag of each channel |
| reloadVal | output | 48 | Assembled reload value of each channel |
| loadStrobe | output | 3 | One-cycle pulse when a reload value is complete |
| chanAccess | output | 6 | Access type of each channel, 2 bits per channel |
| chanMode | output | 9 | Mode of each channel, 3 bits per channel |
| chanBcd | output | 3 | BCD select of each channel |

## Verification
The bench builds the block with its package defaults: three channels and 16-bit counts handled as two bytes. This puts the 1101 and 1110 multi-channel masks and all three access types within reach, and each channel is given a different type. Snapshot freezing is shown by changing the live counts after each snapshot command. Stacked status and count snapshots, repeated commands and the two reserved command codes are each run against the read order that they should produce.

// File: rtl/timer_port_pkg.sv
package timer_port_pkg;
  localparam int CHANS  = 3;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 2;
  localparam int MODE_W = 3;
  localparam int ACC_W  = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd3;

  typedef enum logic [ACC_W-1:0] {
    ACC_SNAP = 2'b00,
    ACC_LOW  = 2'b01,
    ACC_HIGH = 2'b10,
    ACC_WORD = 2'b11
  } access_e;

  // One bit per channel for each action decoded from the bus.
  typedef struct packed {
    logic [CHANS-1:0] prog;
    logic [CHANS-1:0] cntSnap;
    logic [CHANS-1:0] stsSnap;
    logic [CHANS-1:0] wrByte;
    logic [CHANS-1:0] rdByte;
  } strobe_t;
endpackage

// File: rtl/tcp_ctrl.sv
module tcp_ctrl
  import timer_port_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output strobe_t           stb
);
  logic [1:0] cmdSel;
  logic [1:0] cmdSub;
  logic       ctrlWr;

  assign cmdSel = wrData[7:6];
  assign cmdSub = wrData[5:4];
  assign ctrlWr = wrEn && (busAddr == CTRL_ADDR);

  always_comb begin
    stb = '0;
    if (ctrlWr) begin
      if (cmdSel != 2'b11) begin
        for (int ch = 0; ch < CHANS; ch++) begin
          if (cmdSel == ADDR_W'(ch)) begin
            if (cmdSub == ACC_SNAP) stb.cntSnap[ch] = 1'b1;
            else                    stb.prog[ch]    = 1'b1;
          end
        end
      end else if (cmdSub == 2'b01) begin
        stb.cntSnap = wrData[CHANS:1];
      end else if (cmdSub == 2'b10) begin
        stb.stsSnap = wrData[CHANS:1];
      end
    end
    for (int ch = 0; ch < CHANS; ch++) begin
      if (busAddr == ADDR_W'(ch)) begin
        stb.wrByte[ch] = wrEn;
        stb.rdByte[ch] = rdEn;
      end
    end
  end
endmodule

// File: rtl/tcp_datapath.sv
module tcp_datapath
  import timer_port_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [BYTE_W-1:0]       wrData,
  input  logic [CHANS*CNT_W-1:0]  liveCount,
  input  logic [CHANS-1:0]        outPin,
  input  logic [CHANS-1:0]        loadedFlag,
  output logic [BYTE_W-1:0]       rdData,
  output logic [CHANS*CNT_W-1:0]  reloadVal,
  output logic [CHANS-1:0]        loadStrobe,
  output logic [CHANS*ACC_W-1:0]  chanAccess,
  output logic [CHANS*MODE_W-1:0] chanMode,
  output logic [CHANS-1:0]        chanBcd
);
  logic [BYTE_W-1:0] chanRd [CHANS];

  for (genvar g = 0; g < CHANS; g++) begin : gChan
    access_e           acc;
    logic [MODE_W-1:0] mode;
    logic              bcd, wrFf, rdFf, cntHeld, stsHeld, strobeQ;
    logic [BYTE_W-1:0] lowHold, stsHold;
    logic [CNT_W-1:0]  cntHold, reload, live, src;
    logic              readLast;

    assign live     = liveCount[g*CNT_W +: CNT_W];
    assign src      = cntHeld ? cntHold : live;
    assign readLast = (acc != ACC_WORD) || rdFf;

    always_comb begin
      if (stsHeld)                chanRd[g] = stsHold;
      else if (acc == ACC_HIGH)   chanRd[g] = src[CNT_W-1:BYTE_W];
      else if (acc == ACC_LOW)    chanRd[g] = src[BYTE_W-1:0];
      else if (rdFf)              chanRd[g] = src[CNT_W-1:BYTE_W];
      else                        chanRd[g] = src[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc <= ACC_WORD; mode <= '0; bcd <= 1'b0;
        wrFf <= 1'b0; rdFf <= 1'b0; cntHeld <= 1'b0; stsHeld <= 1'b0;
        lowHold <= '0; stsHold <= '0; cntHold <= '0; reload <= '0;
        strobeQ <= 1'b0;
      end else begin
        strobeQ <= 1'b0;
        if (stb.prog[g]) begin
          acc  <= access_e'(wrData[5:4]);
          mode <= wrData[3:1];
          bcd  <= wrData[0];
          wrFf <= 1'b0;
          rdFf <= 1'b0;
        end
        if (stb.wrByte[g]) begin
          unique case (acc)
            ACC_LOW:  begin reload <= {{BYTE_W{1'b0}}, wrData}; strobeQ <= 1'b1; end
            ACC_HIGH: begin reload <= {wrData, {BYTE_W{1'b0}}}; strobeQ <= 1'b1; end
            default: begin
              if (!wrFf) begin
                lowHold <= wrData;
                wrFf    <= 1'b1;
              end else begin
                reload  <= {wrData, lowHold};
                strobeQ <= 1'b1;
                wrFf    <= 1'b0;
              end
            end
          endcase
        end
        if (stb.rdByte[g]) begin
          if (stsHeld) begin
            stsHeld <= 1'b0;
          end else begin
            if (acc == ACC_WORD) rdFf <= ~rdFf;
            if (cntHeld && readLast) cntHeld <= 1'b0;
          end
        end
        if (stb.cntSnap[g] && !cntHeld) begin
          cntHold <= live;
          cntHeld <= 1'b1;
        end
        if (stb.stsSnap[g] && !stsHeld) begin
          stsHold <= {outPin[g], loadedFlag[g], acc[0], acc[1], mode, bcd};
          stsHeld <= 1'b1;
        end
      end
    end

    assign reloadVal[g*CNT_W +: CNT_W]   = reload;
    assign loadStrobe[g]                 = strobeQ;
    assign chanAccess[g*ACC_W +: ACC_W]  = acc;
    assign chanMode[g*MODE_W +: MODE_W]  = mode;
    assign chanBcd[g]                    = bcd;
  end

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < CHANS; ch++)
      if (busAddr == ADDR_W'(ch)) rdData = chanRd[ch];
  end
endmodule

// File: rtl/timer_port.sv
module timer_port
  import timer_port_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    wrEn,
  input  logic [BYTE_W-1:0]       wrData,
  input  logic                    rdEn,
  output logic [BYTE_W-1:0]       rdData,
  input  logic [CHANS*CNT_W-1:0]  liveCount,
  input  logic [CHANS-1:0]        outPin,
  input  logic [CHANS-1:0]        loadedFlag,
  output logic [CHANS*CNT_W-1:0]  reloadVal,
  output logic [CHANS-1:0]        loadStrobe,
  output logic [CHANS*ACC_W-1:0]  chanAccess,
  output logic [CHANS*MODE_W-1:0] chanMode,
  output logic [CHANS-1:0]        chanBcd
);
  strobe_t stb;

  tcp_ctrl u_ctrl (
    .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .stb(stb)
  );

  tcp_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .wrData(wrData),
    .liveCount(liveCount), .outPin(outPin), .loadedFlag(loadedFlag),
    .rdData(rdData), .reloadVal(reloadVal), .loadStrobe(loadStrobe),
    .chanAccess(chanAccess), .chanMode(chanMode), .chanBcd(chanBcd)
  );
endmodule

// File: rtl/timer_port_chk.sv
module timer_port_chk
  import timer_port_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       busAddr,
  input logic                    wrEn,
  input logic [BYTE_W-1:0]       wrData,
  input logic [CHANS*CNT_W-1:0]  reloadVal,
  input logic [CHANS-1:0]        loadStrobe,
  input logic [CHANS*ACC_W-1:0]  chanAccess,
  input logic [CHANS*MODE_W-1:0] chanMode,
  input logic [CHANS-1:0]        chanBcd
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (busAddr == CTRL_ADDR);

  for (genvar g = 0; g < CHANS; g++) begin : gChk
    // R3 / R4: a load strobe only follows a data write to that channel
    a_r3_strobe_after_write: assert property (@(posedge clk) disable iff (!rstN)
      loadStrobe[g] |-> $past(wrEn && (busAddr == ADDR_W'(g))));
    // R2: a programmed access type is never the snapshot code
    a_r2_access_valid: assert property (@(posedge clk) disable iff (!rstN)
      chanAccess[g*ACC_W +: ACC_W] != 2'b00);
  end

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStrobe));

  a_r2_cfg_only_by_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable({chanAccess, chanMode, chanBcd}));

  a_r11_reserved_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && (wrData[7:4] == 4'hC || wrData[7:4] == 4'hF))
      |=> $stable({chanAccess, chanMode, chanBcd}));

  a_r3_reload_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe == '0) |-> $stable(reloadVal));
endmodule

bind timer_port timer_port_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
  .reloadVal(reloadVal), .loadStrobe(loadStrobe), .chanAccess(chanAccess),
  .chanMode(chanMode), .chanBcd(chanBcd)
);

// File: tb/timer_port_test.sv
module timer_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [47:0] liveCount = '0;
  logic [2:0]  outPin = '0;
  logic [2:0]  loadedFlag = '0;
  logic [47:0] reloadVal;
  logic [2:0]  loadStrobe;
  logic [5:0]  chanAccess;
  logic [8:0]  chanMode;
  logic [2:0]  chanBcd;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .liveCount(liveCount), .outPin(outPin),
    .loadedFlag(loadedFlag), .reloadVal(reloadVal), .loadStrobe(loadStrobe),
    .chanAccess(chanAccess), .chanMode(chanMode), .chanBcd(chanBcd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setLive(input int ch, input logic [15:0] v);
    liveCount[ch*16 +: 16] = v;
  endtask

  task automatic wrByte(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdByte(input logic [1:0] a, input logic [7:0] exp, input string tag);
    busAddr = a; rdEn = 1'b1;
    #1;
    check(tag, 32'(rdData), 32'(exp));
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reload", 32'(reloadVal[31:0]), 32'h0);
    check("R1 strobe", 32'(loadStrobe), 32'h0);
    check("R1 access", 32'(chanAccess), 32'b11_11_11);
    check("R1 mode/bcd", 32'({chanMode, chanBcd}), 32'h0);
    rdByte(2'd0, 8'h34, "R1 read low");
    rdByte(2'd0, 8'h12, "R1 read high");
  endtask

  task automatic t_program;
    wrByte(2'd3, 8'h55);              // ch1 low-only, mode 2, BCD
    check("R2 access ch1", 32'(chanAccess[3:2]), 32'h1);
    check("R2 mode ch1", 32'(chanMode[5:3]), 32'h2);
    check("R2 bcd ch1", 32'(chanBcd), 32'b010);
    wrByte(2'd3, 8'hA2);              // ch2 high-only, mode 1, binary
    check("R2 access ch2", 32'(chanAccess[5:4]), 32'h2);
  endtask

  task automatic t_single_writes;
    wrByte(2'd1, 8'h5A);
    check("R3 low strobe", 32'(loadStrobe), 32'b010);
    check("R3 low reload", 32'(reloadVal[31:16]), 32'h005A);
    @(negedge clk);
    check("R3 strobe one cycle", 32'(loadStrobe), 32'h0);
    wrByte(2'd2, 8'h7E);
    check("R3 high reload", 32'(reloadVal[47:32]), 32'h7E00);
    check("R3 high strobe", 32'(loadStrobe), 32'b100);
  endtask

  task automatic t_word_write;
    wrByte(2'd3, 8'h36);              // ch0 two-byte, mode 3
    wrByte(2'd0, 8'h44);
    check("R4 no strobe first", 32'(loadStrobe), 32'h0);
    check("R4 reload unchanged", 32'(reloadVal[15:0]), 32'h0);
    wrByte(2'd0, 8'h11);
    check("R4 strobe second", 32'(loadStrobe), 32'b001);
    check("R4 reload word", 32'(reloadVal[15:0]), 32'h1144);
  endtask

  task automatic t_read_modes;
    rdByte(2'd1, 8'h78, "R5 low-only 1");
    rdByte(2'd1, 8'h78, "R5 low-only 2");
    rdByte(2'd2, 8'h9A, "R5 high-only");
    rdByte(2'd0, 8'h34, "R5 word low");
    wrByte(2'd0, 8'h22);
    rdByte(2'd0, 8'h12, "R5 word high after write");
    wrByte(2'd0, 8'h33);
    check("R5 independent write order", 32'(reloadVal[15:0]), 32'h3322);
    rdByte(2'd0, 8'h34, "R5 partial read");
    wrByte(2'd3, 8'h36);
    rdByte(2'd0, 8'h34, "R5 order reset by programming");
    rdByte(2'd0, 8'h12, "R5 order high");
  endtask

  task automatic t_count_snap;
    wrByte(2'd3, 8'h00);
    setLive(0, 16'hBEEF);
    rdByte(2'd0, 8'h34, "R6 frozen low");
    rdByte(2'd0, 8'h12, "R6 frozen high");
    rdByte(2'd0, 8'hEF, "R6 released low");
    rdByte(2'd0, 8'hBE, "R6 released high");
  endtask

  task automatic t_repeat_snap;
    setLive(0, 16'h1111);
    wrByte(2'd3, 8'h00);
    setLive(0, 16'h2222);
    wrByte(2'd3, 8'h00);
    setLive(0, 16'h3333);
    rdByte(2'd0, 8'h11, "R7 first snapshot kept low");
    rdByte(2'd0, 8'h11, "R7 first snapshot kept high");
    rdByte(2'd0, 8'h33, "R7 live after");
    rdByte(2'd0, 8'h33, "R7 live after high");
  endtask

  task automatic t_multi_snap;
    setLive(0, 16'h0F0E);
    wrByte(2'd3, 8'hDC);              // mask bits 3,2 -> ch2, ch1
    setLive(0, 16'hAAAA); setLive(1, 16'hBBBB); setLive(2, 16'hCCCC);
    rdByte(2'd1, 8'h78, "R8 ch1 frozen");
    rdByte(2'd2, 8'h9A, "R8 ch2 frozen");
    rdByte(2'd0, 8'hAA, "R8 ch0 not selected");
    rdByte(2'd0, 8'hAA, "R8 ch0 high");
    rdByte(2'd1, 8'hBB, "R8 ch1 released");
    rdByte(2'd2, 8'hCC, "R8 ch2 released");
  endtask

  task automatic t_status;
    outPin = 3'b010; loadedFlag = 3'b100;
    wrByte(2'd3, 8'hE4);              // status of ch1
    outPin = 3'b000;
    rdByte(2'd1, 8'hA5, "R9 ch1 status");
    rdByte(2'd1, 8'hBB, "R9 ch1 count after status");
    wrByte(2'd3, 8'hE8);              // status of ch2
    outPin = 3'b100;
    wrByte(2'd3, 8'hE8);              // ignored, unread status pending
    rdByte(2'd2, 8'h52, "R9 ch2 status first capture");
    rdByte(2'd2, 8'hCC, "R9 ch2 count after status");
  endtask

  task automatic t_status_first;
    setLive(0, 16'h4321); outPin = 3'b001; loadedFlag = 3'b001;
    wrByte(2'd3, 8'h00);
    wrByte(2'd3, 8'hE2);
    setLive(0, 16'h0000); outPin = 3'b000;
    rdByte(2'd0, 8'hF6, "R10 status first");
    rdByte(2'd0, 8'h21, "R10 count low next");
    rdByte(2'd0, 8'h43, "R10 count high next");
    rdByte(2'd0, 8'h00, "R10 live after");
    rdByte(2'd0, 8'h00, "R10 live after high");
  endtask

  task automatic t_ignored;
    wrByte(2'd3, 8'hCE);
    wrByte(2'd3, 8'hFE);
    check("R11 access kept", 32'(chanAccess), 32'b10_01_11);
    check("R11 mode kept", 32'(chanMode), 32'({3'd1, 3'd2, 3'd3}));
    check("R11 bcd kept", 32'(chanBcd), 32'b010);
    setLive(0, 16'h5A6B);
    rdByte(2'd0, 8'h6B, "R11 no snapshot low");
    rdByte(2'd0, 8'h5A, "R11 no snapshot high");
    rdByte(2'd1, 8'hBB, "R11 no status ch1");
  endtask

  initial begin
    setLive(0, 16'h1234); setLive(1, 16'h5678); setLive(2, 16'h9ABC);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_single_writes();
    t_word_write();
    t_read_modes();
    t_count_snap();
    t_repeat_snap();
    t_multi_snap();
    t_status();
    t_status_first();
    t_ignored();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule